// File: doc/BRIEF.md
# Register-Controlled 8-Bit PWM Generator

A single-channel pulse-width modulator driven from one 32-bit control word. Software writes the word through a plain port with no address (a write strobe and write data) and reads it back on a read-data bus that always shows the current register. The input clock first passes through a reload divider that fixes the length of one PWM step. A 256-step counter then forms each period. The output is high at the start of a period and drops low at a point set by the duty field.

The control word layout has four fields. Bit 31 enables the channel. Bit 30 gives the pin level while the channel is off. Bits 15:8 hold the reload value, where 1 to 255 divide by that amount and 0 divides by 256. Bits 7:0 hold the duty value, which counts the low steps at the end of each period. Duty values 1 to 255 give (256 minus value) high steps, and 0 gives no high steps at all.

The reload and duty fields are shadowed. A change to them made while the channel runs waits for the next period boundary, so no period mixes old and new settings. The enable and idle-level bits act at once. Disabling the channel clears both counters, so each enable starts a fresh period at step 0.

Top module: `pwm8_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000 and the output is low.
- R2: A read returns the last written word with bits 29:16 forced to zero; bits 31, 30 and 15:0 read back as written.
- R3: While bit 31 is 0, the output equals bit 30 from the first cycle after the write that set it, including when a running channel is switched off mid-period.
- R4: Each step lasts N input-clock cycles, where N is the value of bits 15:8 for values 1 to 255, and N is 256 when bits 15:8 are 0.
- R5: A period is 256 steps. For a duty value d in bits 7:0 from 1 to 255, the output is high during steps 0 to 255-d and low during the remaining d steps, so d=128 gives 50% high, d=1 gives one low step and d=255 gives one high step.
- R6: A duty value of 0 keeps the output low for the whole period.
- R7: A write to bits 15:0 while the channel runs takes effect at the first step of the next period; the current period finishes with the old reload and duty values.
- R8: Disabling the channel resets the divider and the step counter, so the next enable starts at step 0 with the output high (for nonzero duty) from the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, rising-edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| pwm_out | output | 1 | PWM output pin |

## Verification
The checker checks on every cycle the behaviours that depend only on neighbouring cycles. These are: the reserved bits read zero, the idle level drives the pin while the channel is off, and the step counter holds between divider ticks and advances by one on a tick. It also checks that the shadowed settings change only at a period end, that the counters stay cleared after a disabled cycle, and that step 0 and duty 0 give the right output level. The full waveform shape can only be shown by the bench's scenarios. This covers the exact high and low step counts for each duty value, the step length for each reload value including the divide-by-256 case, the deferral of a mid-period write to the next period, and the clean restart after a disable.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;

  localparam int REG_W      = 32;
  localparam int STEP_W     = 8;
  localparam int STEPS      = 1 << STEP_W;
  localparam int EN_BIT     = 31;
  localparam int IDLE_BIT   = 30;
  localparam int CFG_W      = 2 * STEP_W;
  localparam int RELOAD_LSB = STEP_W;
  localparam int DUTY_LSB   = 0;

  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << EN_BIT) | (REG_W'(1) << IDLE_BIT) | REG_W'((1 << CFG_W) - 1);

  typedef struct packed {
    logic [STEP_W-1:0] reload;
    logic [STEP_W-1:0] duty;
  } pwm8_cfg_t;

  // Step length in input cycles: a reload of zero stands for the full count.
  function automatic logic [STEP_W:0] pwm8_divisor(input logic [STEP_W-1:0] r);
    return (r == '0) ? (STEP_W+1)'(STEPS) : {1'b0, r};
  endfunction

  // Last divider count value before a tick; wraps so that zero gives STEPS-1.
  function automatic logic [STEP_W-1:0] pwm8_last_count(input logic [STEP_W-1:0] r);
    return r - STEP_W'(1);
  endfunction

  // Number of high steps per period for a duty field value.
  function automatic logic [STEP_W:0] pwm8_high_steps(input logic [STEP_W-1:0] d);
    return (d == '0) ? '0 : ((STEP_W+1)'(STEPS) - {1'b0, d});
  endfunction

endpackage

// File: rtl/pwm8_ctrl_reg.sv
module pwm8_ctrl_reg
  import pwm8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             period_end,
  output logic [REG_W-1:0] ctrl_q,
  output pwm8_cfg_t        cfg_q
);

  logic [REG_W-1:0] ctrl_d;
  logic             cfg_load;

  assign ctrl_d   = wr_en ? (wr_data & WR_MASK) : ctrl_q;
  assign cfg_load = !ctrl_q[EN_BIT] || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (cfg_load) cfg_q <= pwm8_cfg_t'(ctrl_d[CFG_W-1:0]);
    end
  end

endmodule

// File: rtl/pwm8_prescaler.sv
module pwm8_prescaler
  import pwm8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [STEP_W-1:0] reload,
  output logic [STEP_W-1:0] pre_cnt,
  output logic              tick
);

  assign tick = run && (pre_cnt == pwm8_last_count(reload));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (!run)   pre_cnt <= '0;
    else if (tick)   pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + STEP_W'(1);
  end

endmodule

// File: rtl/pwm8_stepper.sv
module pwm8_stepper
  import pwm8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [STEP_W-1:0] duty,
  output logic [STEP_W-1:0] step_cnt,
  output logic              period_end,
  output logic              cmp_high
);

  assign period_end = tick && (step_cnt == '1);
  assign cmp_high   = ({1'b0, step_cnt} < pwm8_high_steps(duty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step_cnt <= '0;
    else if (!run)  step_cnt <= '0;
    else if (tick)  step_cnt <= step_cnt + STEP_W'(1);
  end

endmodule

// File: rtl/pwm8_ctrl.sv
module pwm8_ctrl
  import pwm8_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);

  logic [REG_W-1:0]  ctrl_q;
  pwm8_cfg_t         cfg_q;
  logic              run_en;
  logic              idle_lvl;
  logic [STEP_W-1:0] pre_cnt;
  logic              step_tick;
  logic [STEP_W-1:0] step_cnt;
  logic              period_end;
  logic              cmp_high;

  assign run_en   = ctrl_q[EN_BIT];
  assign idle_lvl = ctrl_q[IDLE_BIT];

  pwm8_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .period_end (period_end),
    .ctrl_q     (ctrl_q),
    .cfg_q      (cfg_q)
  );

  pwm8_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_en),
    .reload  (cfg_q.reload),
    .pre_cnt (pre_cnt),
    .tick    (step_tick)
  );

  pwm8_stepper u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_en),
    .tick       (step_tick),
    .duty       (cfg_q.duty),
    .step_cnt   (step_cnt),
    .period_end (period_end),
    .cmp_high   (cmp_high)
  );

  assign rd_data = ctrl_q;
  assign pwm_out = run_en ? cmp_high : idle_lvl;

endmodule

// File: rtl/pwm8_ctrl_chk.sv
module pwm8_ctrl_chk
  import pwm8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  rd_data,
  input logic              pwm_out,
  input logic [STEP_W-1:0] pre_cnt,
  input logic              tick,
  input logic [STEP_W-1:0] step,
  input logic              period_end,
  input logic [CFG_W-1:0]  cfg
);

  logic en;
  assign en = rd_data[EN_BIT];

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[IDLE_BIT-1:CFG_W] == '0);

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (pwm_out == rd_data[IDLE_BIT]));

  p_step_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick)) |-> (step == $past(step)));

  p_step_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(tick)) |-> (step == $past(step) + STEP_W'(1)));

  p_first_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step == '0 && cfg[STEP_W-1:0] != '0) |-> pwm_out);

  p_duty0_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cfg[STEP_W-1:0] == '0) |-> !pwm_out);

  p_cfg_defer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(period_end)) |-> $stable(cfg));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (pre_cnt == '0 && step == '0));

endmodule

bind pwm8_ctrl pwm8_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_data    (rd_data),
  .pwm_out    (pwm_out),
  .pre_cnt    (pre_cnt),
  .tick       (step_tick),
  .step       (step_cnt),
  .period_end (period_end),
  .cfg        (cfg_q)
);

// File: tb/pwm8_ctrl_bench.sv
`timescale 1ns/1ps
module pwm8_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pwm8_ctrl u_pwm8_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  function automatic int step_len(input int reload);
    return (reload == 0) ? 256 : reload;
  endfunction

  function automatic bit level_at(input int k, input int reload, input int duty);
    int st;
    int hi;
    st = (k / step_len(reload)) % 256;
    hi = (duty == 0) ? 0 : 256 - duty;
    return st < hi;
  endfunction

  function automatic logic [31:0] word(input bit en, input bit idle, input int reload, input int duty);
    return {en, idle, 14'd0, reload[7:0], duty[7:0]};
  endfunction

  task automatic chk_bit(input logic got, input logic exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_word(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // Starts a fresh period and checks n cycles of output against the model.
  task automatic run_fresh(input int reload, input int duty, input bit idle,
                           input int n, input string tag);
    wr(word(1'b0, idle, reload, duty));
    chk_bit(pwm_out, idle, "R3 idle before enable");
    wr(word(1'b1, idle, reload, duty));
    for (int k = 0; k < n; k++) begin
      chk_bit(pwm_out, level_at(k, reload, duty), tag);
      @(negedge clk);
    end
    wr(word(1'b0, idle, reload, duty));
    chk_bit(pwm_out, idle, "R3 idle after disable");
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk_word(rd_data, 32'h0, "R1 reset register");
    chk_bit(pwm_out, 1'b0, "R1 reset output");
    rst_n = 1'b1;
    @(negedge clk);
    chk_word(rd_data, 32'h0, "R1 register after release");
    chk_bit(pwm_out, 1'b0, "R1 output after release");

    // R2: reserved bits read zero
    wr(32'h7FFF_FFFF);
    chk_word(rd_data, 32'h4000_FFFF, "R2 readback masked");
    chk_bit(pwm_out, 1'b1, "R3 idle high");
    wr(32'h3A5A_1234);
    chk_word(rd_data, 32'h0000_1234, "R2 readback idle low");
    chk_bit(pwm_out, 1'b0, "R3 idle low");

    // R5 directed duty corners at unit step length
    run_fresh(1, 128, 1'b0, 256, "R5 duty 128 half");
    run_fresh(1, 1,   1'b1, 256, "R5 duty 1");
    run_fresh(1, 255, 1'b1, 256, "R5 duty 255");
    // R6 duty zero over a full period and into the next
    run_fresh(1, 0,   1'b1, 300, "R6 duty zero low");
    // R4 divide by 256 when reload is zero; duty 255 gives exactly one high step
    run_fresh(0, 255, 1'b0, 600, "R4 reload zero step 256");
    run_fresh(3, 250, 1'b0, 60,  "R4 reload 3");

    // R7: mid-period change waits for the boundary
    wr(word(1'b0, 1'b0, 1, 200));
    wr(word(1'b1, 1'b0, 1, 200));
    for (int k = 0; k < 520; k++) begin
      if (k == 10) begin
        @(negedge clk);
        wr_en = 1'b1; wr_data = word(1'b1, 1'b0, 1, 50);
        @(negedge clk);
        wr_en = 1'b0;
        k = 12;
      end
      if (k < 256) chk_bit(pwm_out, level_at(k, 1, 200), "R7 old settings hold");
      else         chk_bit(pwm_out, level_at(k, 1, 50),  "R7 new settings applied");
      @(negedge clk);
    end

    // R8: disable mid-period then restart from step 0
    for (int k = 0; k < 100; k++) @(negedge clk);
    wr(word(1'b0, 1'b0, 1, 200));
    chk_bit(pwm_out, 1'b0, "R3 mid-period disable");
    wr(word(1'b1, 1'b0, 1, 200));
    for (int k = 0; k < 256; k++) begin
      chk_bit(pwm_out, level_at(k, 1, 200), "R8 restart at step 0");
      @(negedge clk);
    end
    wr(word(1'b0, 1'b0, 1, 200));

    // Random settings, full period each
    for (int it = 0; it < 16; it++) begin
      int rl;
      int dt;
      bit il;
      rl = 1 + int'($urandom_range(2, 0));
      dt = int'($urandom_range(255, 0));
      il = 1'($urandom_range(1, 0));
      run_fresh(rl, dt, il, 256 * rl, "R5 random pattern");
    end

    finished = 1;
    summary();
  end

endmodule